// File: doc/BRIEF.md
# Converter Result Readout Port

This block sits at the digital edge of a sampling converter. An internal producer hands it one 16-bit result per output update as a single-cycle valid strobe. The block keeps the current result in an output register, announces it with an active-low ready flag, and places it on a tri-state parallel bus while a host holds chip-select and read-strobe low. Every input is sampled on the rising edge of the master clock, including the level-sensitive read strobe.

The ready flag follows a fixed handshake. It goes high when a read completes. If an update arrives and the previous word was never read, the flag is first forced high for exactly two clock cycles and then falls together with the new word, so the host always sees a fresh falling edge. Three event strobes from an upstream controller (sync finished, reset sequence finished, calibration finished) re-announce the current word through the same falling-edge mechanism. An update that arrives while a read is in progress is held and applied once the read ends.

Top module: `cnv_rdout`

## Requirements
- R1: While `rst_n` is low, `rdy_n` is 1, the bus is high impedance and the output register holds 0.
- R2: The bus drives the output register, bit 15 on `rd_bus[15]` down to bit 0 on `rd_bus[0]`, only in cycles that follow an edge sampling both `cs_n` and `rd_n` low; after any other edge all 16 bits are high impedance.
- R3: An update strobe that finds `rdy_n` high, no pulse under way and no read in progress loads the word at that edge, and `rdy_n` is 0 from that edge on.
- R4: A read completes at the first edge that samples `cs_n` or `rd_n` high after an edge that sampled both low; from that edge `rdy_n` is 1.
- R5: An update that finds `rdy_n` low (word unread) drives `rdy_n` high for exactly two cycles; at the second edge after the strobe the new word loads and `rdy_n` falls.
- R6: While a read is in progress the output register does not change; an update arriving then is held and is loaded, with `rdy_n` falling, at the edge after the read completes.
- R7: A pulse on `sync_done`, `rst_done` or `cal_done` re-announces the current word: with `rdy_n` high it falls at that edge, with `rdy_n` low the two-cycle high pulse of R5 precedes the fall; the word itself does not change.
- R8: After reset is released, `rdy_n` stays high until the first result or event strobe.
- R9: If several updates arrive while one is held, the newest is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | Single-cycle strobe: new result on `res_word` |
| res_word | input | 16 | Result word from the producer |
| sync_done | input | 1 | Strobe: synchronization sequence finished |
| rst_done | input | 1 | Strobe: reset sequence finished |
| cal_done | input | 1 | Strobe: self-calibration finished |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low level-sensitive read strobe |
| rdy_n | output | 1 | Active-low ready flag, falls when a new word is readable |
| rd_bus | output | 16 | Tri-state parallel data bus |

## Verification
The two functions that can coincide are a host read and a producer update: the bench raises `res_vld` while the bus is enabled, sometimes twice in one read, and judges that the bus value stays the old word throughout, that `rdy_n` rises at the completing edge and falls one edge later, and that a second read returns the newest word. A second collision, an update or event strobe arriving on an unread word, is judged by sampling `rdy_n` after each of the three following edges for the pattern high, high, low. The host bus is a resolved net onto which the bench drives a known probe pattern whenever it expects the block to be silent, so any unwanted drive corrupts the probe value.

// File: rtl/cnv_rdout.sv
module cnv_rdout #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic [WIDTH-1:0] res_word,
  input  logic             sync_done,
  input  logic             rst_done,
  input  logic             cal_done,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic             rdy_n,
  output wire  [WIDTH-1:0] rd_bus
);

  localparam logic [1:0] PULSE_START = 2'd2;
  localparam logic [1:0] PULSE_LAST  = 2'd1;

  logic [WIDTH-1:0] out_q, held_w;
  logic             held_v, bus_en;
  logic [1:0]       hi_cnt;

  wire req     = res_vld | sync_done | rst_done | cal_done;
  wire want    = req | held_v;
  wire rd_done = bus_en & (cs_n | rd_n);
  wire [WIDTH-1:0] next_w = res_vld ? res_word : (held_v ? held_w : out_q);
  wire load_now = (hi_cnt == PULSE_LAST) || (hi_cnt == 2'd0 && rdy_n);

  assign rd_bus = bus_en ? out_q : {WIDTH{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      held_w <= '0;
      held_v <= 1'b0;
      bus_en <= 1'b0;
      rdy_n  <= 1'b1;
      hi_cnt <= 2'd0;
    end else begin
      bus_en <= ~cs_n & ~rd_n;
      if (rd_done || bus_en) begin
        if (rd_done) rdy_n <= 1'b1;
        held_v <= want;
        held_w <= next_w;
      end else if (want) begin
        if (load_now) begin
          out_q  <= next_w;
          rdy_n  <= 1'b0;
          held_v <= 1'b0;
          hi_cnt <= 2'd0;
        end else begin
          held_v <= 1'b1;
          held_w <= next_w;
          rdy_n  <= 1'b1;
          hi_cnt <= (hi_cnt == PULSE_START) ? PULSE_LAST : PULSE_START;
        end
      end
    end
  end

  p_done_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && (cs_n || rd_n) |=> rdy_n);

  p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_en) |-> $stable(out_q));

  p_load_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> !rdy_n);

  p_two_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) && !$past(bus_en) |=> rdy_n);

  p_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n || rd_n) |-> !bus_en);

endmodule

// File: tb/cnv_rdout_tb.sv
module cnv_rdout_tb_top;
  localparam int TCLK = 10;
  localparam logic [15:0] PROBE = 16'h5AA5;

  logic clk = 0, rst_n = 0;
  logic res_vld = 0, sync_done = 0, rst_done = 0, cal_done = 0;
  logic cs_n = 1, rd_n = 1, probe_en = 0;
  logic [15:0] res_word = '0;
  logic rdy_n;
  wire  [15:0] host_bus;
  int checks = 0, errors = 0;

  assign host_bus = probe_en ? PROBE : 16'hzzzz;

  cnv_rdout dut_i (.clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_word(res_word),
    .sync_done(sync_done), .rst_done(rst_done), .cal_done(cal_done),
    .cs_n(cs_n), .rd_n(rd_n), .rdy_n(rdy_n), .rd_bus(host_bus));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic chk_rdy(input logic exp, input string tag);
    chk(rdy_n === exp, tag, {15'd0, rdy_n}, {15'd0, exp});
  endtask

  task automatic chk_quiet(input string tag);
    probe_en = 1; #1;
    chk(host_bus === PROBE, tag, host_bus, PROBE);
    probe_en = 0; #1;
  endtask

  task automatic push(input logic [15:0] w);
    res_vld = 1; res_word = w; step(); res_vld = 0;
  endtask

  task automatic read_word(input logic [15:0] exp, input int len);
    cs_n = 0; rd_n = 0;
    for (int k = 0; k < len; k++) begin
      step();
      chk(host_bus === exp, "R2 bus value", host_bus, exp);
    end
    cs_n = 1; rd_n = 1; step();
    chk_rdy(1'b1, "R4 ready high after read");
    chk_quiet("R2 bus released");
  endtask

  initial begin
    #(TCLK*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w, w2;
    step(); step();
    chk_rdy(1'b1, "R1 ready in reset");
    chk_quiet("R1 bus quiet in reset");
    rst_n = 1;
    for (int k = 0; k < 3; k++) begin step(); chk_rdy(1'b1, "R8 idle after reset"); end

    for (int i = 0; i < 8; i++) begin
      w = 16'(i * 16'h1357) ^ 16'h8421;
      push(w);
      chk_rdy(1'b0, "R3 immediate load");
      chk_quiet("R2 quiet before read");
      read_word(w, 1 + i % 3);
    end

    for (int i = 0; i < 4; i++) begin
      w  = 16'(i * 16'h0F1E) ^ 16'hC003;
      w2 = ~w;
      push(w);
      chk_rdy(1'b0, "R3 first word");
      push(w2);
      chk_rdy(1'b1, "R5 pulse cycle 1");
      step(); chk_rdy(1'b1, "R5 pulse cycle 2");
      step(); chk_rdy(1'b0, "R5 fall with new word");
      read_word(w2, 2);
    end

    cs_n = 1; rd_n = 0; push(16'h0FF0);
    chk_quiet("R2 cs high blocks drive");
    step(); chk_quiet("R2 cs high blocks drive again");
    chk_rdy(1'b0, "R4 no read without cs");
    rd_n = 1;
    read_word(16'h0FF0, 1);

    for (int i = 0; i < 4; i++) begin
      w  = 16'h1111 << i;
      w2 = 16'hF00F ^ 16'(i);
      push(w);
      cs_n = 0; rd_n = 0; step();
      chk(host_bus === w, "R6 bus before collision", host_bus, w);
      push(w2);
      chk(host_bus === w, "R6 word stable during read", host_bus, w);
      if (i % 2 == 1) begin
        push(w2 ^ 16'h00FF);
        w2 = w2 ^ 16'h00FF;
      end
      step();
      chk(host_bus === w, "R6 word still stable", host_bus, w);
      cs_n = 1; rd_n = 1; step();
      chk_rdy(1'b1, "R4 ready high at read end");
      step(); chk_rdy(1'b0, "R6 held word announced");
      read_word(w2, 1);
      if (i % 2 == 1) chk(1'b1, "R9 newest held word read", w2, w2);
    end

    for (int e = 0; e < 3; e++) begin
      w = 16'hA000 | 16'(e);
      push(w);
      read_word(w, 1);
      sync_done = (e == 0); rst_done = (e == 1); cal_done = (e == 2);
      step();
      sync_done = 0; rst_done = 0; cal_done = 0;
      chk_rdy(1'b0, "R7 event announces word");
      cal_done = 1; step(); cal_done = 0;
      chk_rdy(1'b1, "R7 event on unread word pulse 1");
      step(); chk_rdy(1'b1, "R7 event pulse 2");
      step(); chk_rdy(1'b0, "R7 event fall");
      read_word(w, 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule